// File: doc/BRIEF.md
# HDMI-CEC Frame Transmitter

This block sends one CEC frame over a single shared open-drain line. Before a frame, software fills a small byte buffer through a simple write port. It then pulses `start` together with a byte count and the per-frame options. The engine first waits until the line has stayed released for a selectable number of bit periods. It then produces the start symbol. For each byte it sends eight data bits, highest bit first, followed by an end-of-message bit and an acknowledge slot. The line is only ever pulled low or released: `cec_oe` high means "pull low", and the resolved line level comes back on `cec_in`.

All symbol timing is counted in ticks of 0.1 ms. The tick comes from a divider whose divisor `div_value` is the input clock frequency divided by 10000. A data bit lasts 24 ticks. A one is held low for 6 ticks and a zero for 15 ticks. The start symbol is held low for 37 of its 45 ticks. The engine reads the line 10.5 ticks after each falling edge. At that point it checks whether a released bit was overwritten by another initiator, and it samples the acknowledge from the receiver. A frame ends with a one-cycle `done` pulse, sticky result flags and a two-bit result code.

Top module: `cec_frame_tx`

## Requirements
- R1: One tick equals `div_value` clock cycles, counted from the cycle that accepts `start`. The start symbol pulls the line low for 37 ticks, then releases it for 8 ticks.
- R2: Each byte is sent highest bit first. Every bit lasts 24 ticks. A one is pulled low for the first 6 ticks and a zero for the first 15 ticks.
- R3: Before the first symbol, the line must be seen released for N*24 consecutive ticks. N is 3 when `sft_sel`=0, 5 when `sft_sel`=1 and 7 when `sft_sel`=2 or 3. Any low level seen during the wait restarts the count.
- R4: With `auto_som`=0 no start symbol is sent, and the first data bit follows the wait directly.
- R5: With `auto_eom`=1 the end-of-message bit is a one on the last byte and a zero on the others. With `auto_eom`=0 it is a zero on every byte.
- R6: The acknowledge slot is driven as a one. A byte counts as acknowledged when the line reads low at the sample point, 10.5 ticks after the slot starts.
- R7: With `stop_on_nack`=1 the frame ends 24 ticks after the start of the first unacknowledged slot. With `stop_on_nack`=0 all bytes are sent. Either way a missing acknowledge makes the result NACK and `ack_ok` low.
- R8: The arbitration check applies to data and end-of-message bits sent as a one. If the line reads low at the sample point of such a bit, the engine releases the line, pulses `done` in that cycle and sets `arb_err`.
- R9: A byte count of 0 or above 16 causes no line activity. `busy` stays low, and `done` and `tx_err` are set in the cycle that accepts `start`.
- R10: `done` is a one-cycle pulse that arrives together with `busy` falling. Flags and result hold from that point until the next accepted start, which clears them. The result code is 3 for a transmit error, 2 for lost arbitration, 1 for a missing acknowledge and 0 for success, checked in that priority order.
- R11: A `start` pulse while `busy` is high is ignored, and the frame in progress is unchanged.
- R12: `cec_oe` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_value | input | 16 | Clock cycles per 0.1 ms tick |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 4 | Buffer byte index |
| wr_data | input | 8 | Buffer byte value |
| start | input | 1 | Frame start command, one cycle |
| byte_count | input | 5 | Number of bytes to send |
| sft_sel | input | 2 | Signal-free time selector |
| auto_som | input | 1 | Generate the start symbol |
| auto_eom | input | 1 | Generate the end-of-message bit |
| stop_on_nack | input | 1 | Abort on the first missing acknowledge |
| cec_in | input | 1 | Resolved line level |
| cec_oe | output | 1 | Pull the line low when high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished, one-cycle pulse |
| ack_ok | output | 1 | Every byte was acknowledged |
| arb_err | output | 1 | Arbitration was lost |
| tx_err | output | 1 | Start refused because of a bad byte count |
| result | output | 2 | Result code, see R10 |

## Verification
The assertions assume the following about the inputs: `div_value` stays constant during a frame and exceeds the synchronizer depth plus one, `start` lasts one cycle, and the buffer is not written while `busy` is high. The bench follows these rules. It uses divisors of 6 and 8, changes the emulated remote initiator only a half cycle after a tick boundary, and writes the buffer only between frames. Under those conditions the line level read at each sample point is the one the tick schedule predicts.

// File: rtl/cec_tx_pkg.sv
`timescale 1ns/1ps
package cec_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FREE, ST_SOM, ST_DATA, ST_EOM, ST_ACK
   } tx_state_e;

   localparam logic [1:0] RES_OK    = 2'd0;
   localparam logic [1:0] RES_NACK  = 2'd1;
   localparam logic [1:0] RES_ARB   = 2'd2;
   localparam logic [1:0] RES_TXERR = 2'd3;

   // bit periods of released line required before a frame
   function automatic int unsigned free_periods(input logic [1:0] sel);
      case (sel)
         2'd0:    return 3;
         2'd1:    return 5;
         default: return 7;
      endcase
   endfunction
endpackage

// File: rtl/cec_tick_gen.sv
`timescale 1ns/1ps
module cec_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_value,
   output logic             tick,
   output logic             half
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt == div_value - DIV_W'(1));
   assign half = (cnt == (div_value >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart || tick) cnt <= '0;
      else                     cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/cec_line_sync.sv
`timescale 1ns/1ps
module cec_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign line_out = line_in;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2+((STAGES==1)?1:0):0], line_in} >> ((STAGES==1)?1:0) | ((STAGES==1)? STAGES'(line_in) : '0);
         end
         assign line_out = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cec_tx_store.sv
`timescale 1ns/1ps
module cec_tx_store #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [DEPTH*8-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= 8'h00;
         else if (wr_en && (wr_addr == AW'(g)))  q <= wr_data;
      end
      assign flat[g*8 +: 8] = q;
   end

   assign rd_data = flat[{rd_addr, 3'b000} +: 8];
endmodule

// File: rtl/cec_frame_tx.sv
`timescale 1ns/1ps
module cec_frame_tx #(
   parameter int DIV_W       = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SOM_LOW_T   = 37,
   parameter int SOM_ALL_T   = 45,
   parameter int ONE_LOW_T   = 6,
   parameter int ZERO_LOW_T  = 15,
   parameter int BIT_T       = 24,
   parameter int SAMPLE_T    = 10,
   parameter int MAX_FREE    = 7,
   localparam int AW         = $clog2(DEPTH),
   localparam int CW         = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_value,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             start,
   input  logic [CW-1:0]    byte_count,
   input  logic [1:0]       sft_sel,
   input  logic             auto_som,
   input  logic             auto_eom,
   input  logic             stop_on_nack,
   input  logic             cec_in,
   output logic             cec_oe,
   output logic             busy,
   output logic             done,
   output logic             ack_ok,
   output logic             arb_err,
   output logic             tx_err,
   output logic [1:0]       result
);
   import cec_tx_pkg::*;

   localparam int TW = $clog2(MAX_FREE * BIT_T + 1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (!(ONE_LOW_T < SAMPLE_T && SAMPLE_T < ZERO_LOW_T && ZERO_LOW_T < BIT_T)) begin : g_bad_bit
         $error("bit timing must satisfy one-low < sample < zero-low < bit");
      end
      if (SOM_LOW_T >= SOM_ALL_T || SOM_ALL_T > MAX_FREE * BIT_T) begin : g_bad_som
         $error("start symbol timing out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   tx_state_e       state;
   logic [TW-1:0]   tcnt;
   logic [2:0]      bit_idx;
   logic [AW-1:0]   byte_idx;
   logic [AW-1:0]   last_idx;
   logic [1:0]      sft_q;
   logic            som_q, eom_q, stop_q;
   logic            nack_seen, ack_now, oe_q;
   logic            ack_ok_q, arb_q, txe_q, nack_q;

   logic            tick, half, line_hi, restart;
   logic [7:0]      cur_byte;
   logic            cur_one, count_ok, sample, missed, finishing;
   logic [TW-1:0]   tnext, low_len, sym_len;

   assign restart  = (state == ST_IDLE) && start;
   assign count_ok = (byte_count != '0) && (byte_count <= CW'(DEPTH));

   cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(restart), .div_value(div_value),
      .tick(tick), .half(half)
   );

   cec_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(cec_in), .line_out(line_hi)
   );

   cec_tx_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(byte_idx), .rd_data(cur_byte)
   );

   always_comb begin
      case (state)
         ST_DATA: cur_one = cur_byte[bit_idx];
         ST_EOM:  cur_one = eom_q && (byte_idx == last_idx);
         ST_ACK:  cur_one = 1'b1;
         default: cur_one = 1'b0;
      endcase
      case (state)
         ST_SOM:                  low_len = TW'(SOM_LOW_T);
         ST_DATA, ST_EOM, ST_ACK: low_len = cur_one ? TW'(ONE_LOW_T) : TW'(ZERO_LOW_T);
         default:                 low_len = '0;
      endcase
      case (state)
         ST_FREE: sym_len = TW'(free_periods(sft_q) * BIT_T);
         ST_SOM:  sym_len = TW'(SOM_ALL_T);
         default: sym_len = TW'(BIT_T);
      endcase
   end

   assign tnext     = tcnt + TW'(1);
   assign sample    = half && (tcnt == TW'(SAMPLE_T));
   assign missed    = !ack_now;
   assign finishing = (missed && stop_q) || (byte_idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tcnt      <= '0;
         bit_idx   <= 3'd7;
         byte_idx  <= '0;
         last_idx  <= '0;
         sft_q     <= '0;
         som_q     <= 1'b0;
         eom_q     <= 1'b0;
         stop_q    <= 1'b0;
         nack_seen <= 1'b0;
         ack_now   <= 1'b0;
         oe_q      <= 1'b0;
         done      <= 1'b0;
         ack_ok_q  <= 1'b0;
         arb_q     <= 1'b0;
         txe_q     <= 1'b0;
         nack_q    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  ack_ok_q <= 1'b0;
                  arb_q    <= 1'b0;
                  nack_q   <= 1'b0;
                  txe_q    <= !count_ok;
                  done     <= !count_ok;
                  if (count_ok) begin
                     state     <= ST_FREE;
                     tcnt      <= '0;
                     bit_idx   <= 3'd7;
                     byte_idx  <= '0;
                     last_idx  <= AW'(byte_count - CW'(1));
                     sft_q     <= sft_sel;
                     som_q     <= auto_som;
                     eom_q     <= auto_eom;
                     stop_q    <= stop_on_nack;
                     nack_seen <= 1'b0;
                  end
               end
            end
            ST_FREE: begin
               if (!line_hi) begin
                  tcnt <= '0;
               end else if (tick) begin
                  if (tnext == sym_len) begin
                     tcnt  <= '0;
                     state <= som_q ? ST_SOM : ST_DATA;
                     oe_q  <= 1'b1;
                  end else begin
                     tcnt <= tnext;
                  end
               end
            end
            default: begin
               if (sample && (state == ST_DATA || state == ST_EOM) && cur_one && !line_hi) begin
                  state    <= ST_IDLE;
                  oe_q     <= 1'b0;
                  done     <= 1'b1;
                  arb_q    <= 1'b1;
                  ack_ok_q <= 1'b0;
               end else begin
                  if (sample && state == ST_ACK) ack_now <= !line_hi;
                  if (tick) begin
                     if (tnext == low_len) oe_q <= 1'b0;
                     if (tnext == sym_len) begin
                        tcnt <= '0;
                        oe_q <= 1'b1;
                        case (state)
                           ST_SOM: begin
                              state   <= ST_DATA;
                              bit_idx <= 3'd7;
                           end
                           ST_DATA: begin
                              if (bit_idx == 3'd0) state <= ST_EOM;
                              else                 bit_idx <= bit_idx - 3'd1;
                           end
                           ST_EOM: state <= ST_ACK;
                           default: begin
                              if (finishing) begin
                                 state    <= ST_IDLE;
                                 oe_q     <= 1'b0;
                                 done     <= 1'b1;
                                 nack_q   <= nack_seen || missed;
                                 ack_ok_q <= !(nack_seen || missed);
                              end else begin
                                 state     <= ST_DATA;
                                 bit_idx   <= 3'd7;
                                 byte_idx  <= byte_idx + AW'(1);
                                 nack_seen <= nack_seen || missed;
                              end
                           end
                        endcase
                     end else begin
                        tcnt <= tnext;
                     end
                  end
               end
            end
         endcase
      end
   end

   assign cec_oe  = oe_q;
   assign busy    = (state != ST_IDLE);
   assign ack_ok  = ack_ok_q;
   assign arb_err = arb_q;
   assign tx_err  = txe_q;
   assign result  = txe_q ? RES_TXERR : arb_q ? RES_ARB : nack_q ? RES_NACK : RES_OK;
endmodule

// File: rtl/cec_frame_tx_chk.sv
`timescale 1ns/1ps
module cec_frame_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       cec_oe,
   input logic       ack_ok,
   input logic       arb_err,
   input logic       tx_err,
   input logic [1:0] result
);
   assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cec_oe);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_ok_means_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'd0) |-> ack_ok);

   assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!start ##1 !done) |-> $stable({ack_ok, arb_err, tx_err, result}));

   assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_err) |-> (done && !cec_oe));

   assert_txerr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_err) |-> (done && !cec_oe && !busy && !$past(busy)));
endmodule

bind cec_frame_tx cec_frame_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .cec_oe(cec_oe), .ack_ok(ack_ok), .arb_err(arb_err), .tx_err(tx_err),
   .result(result)
);

// File: tb/cec_frame_tx_bench.sv
`timescale 1ns/1ps
module cec_frame_tx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div_value = 16'd8;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        start = 1'b0;
   logic [4:0]  byte_count = '0;
   logic [1:0]  sft_sel = '0;
   logic        auto_som = 1'b1, auto_eom = 1'b1, stop_on_nack = 1'b1;
   logic        peer_low = 1'b0;
   logic        cec_in, cec_oe, busy, done, ack_ok, arb_err, tx_err;
   logic [1:0]  result;

   assign cec_in = ~(cec_oe | peer_low);

   always #2.5 clk = ~clk;

   cec_frame_tx u_cec_frame_tx (
      .clk(clk), .rst_n(rst_n), .div_value(div_value), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
      .byte_count(byte_count), .sft_sel(sft_sel), .auto_som(auto_som),
      .auto_eom(auto_eom), .stop_on_nack(stop_on_nack), .cec_in(cec_in),
      .cec_oe(cec_oe), .busy(busy), .done(done), .ack_ok(ack_ok),
      .arb_err(arb_err), .tx_err(tx_err), .result(result)
   );

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   // frame description used by the reference model
   int         f_div, f_n, f_sft, f_hold, arb_byte, arb_bit, inject_n;
   bit         f_som, f_eom, f_stop;
   logic [7:0] f_bytes [16];
   bit         f_ack [16];
   bit         m_exp [$];
   bit         m_peer [$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push_iv(input bit e, input bit p);
      m_exp.push_back(e);
      m_peer.push_back(p);
   endtask

   task automatic push_sym(input int low, input bit pl);
      for (int t = 0; t < 24; t++) push_iv(t < low, pl && t < 15);
   endtask

   task automatic set_defaults();
      f_div = 8; f_n = 1; f_sft = 0; f_hold = 0;
      arb_byte = -1; arb_bit = 0; inject_n = -1;
      f_som = 1; f_eom = 1; f_stop = 1;
      for (int i = 0; i < 16; i++) begin
         f_bytes[i] = 8'h00;
         f_ack[i] = 1'b1;
      end
   endtask

   task automatic run_frame(input string req);
      int  done_n, nfree, base, bad_oe, bad_done, bad_busy;
      bit  txe, arb, nack, fin;
      int  e_res, got_res, got_ack, got_arb, got_txe;
      m_exp.delete();
      m_peer.delete();
      txe = (f_n == 0 || f_n > 16);
      arb = 0; nack = 0; fin = 0; done_n = 0;
      got_res = 0; got_ack = 0; got_arb = 0; got_txe = 0;
      bad_oe = 0; bad_done = 0; bad_busy = 0;
      if (!txe) begin
         for (int i = 0; i < f_hold; i++) push_iv(1'b0, 1'b1);
         nfree = (f_sft == 0) ? 3 : (f_sft == 1) ? 5 : 7;
         for (int i = 0; i < nfree * 24; i++) push_iv(1'b0, 1'b0);
         if (f_som) begin
            for (int i = 0; i < 37; i++) push_iv(1'b1, 1'b0);
            for (int i = 0; i < 8; i++) push_iv(1'b0, 1'b0);
         end
         for (int i = 0; i < f_n && !fin; i++) begin
            for (int k = 7; k >= 0 && !fin; k--) begin
               bit pl;
               pl = (i == arb_byte) && ((7 - k) == arb_bit);
               if (pl) begin
                  base = m_exp.size();
                  done_n = base * f_div + 10 * f_div + f_div / 2 + 1;
                  arb = 1; fin = 1;
               end
               push_sym(f_bytes[i][k] ? 6 : 15, pl);
            end
            if (!fin) begin
               bit ev, pl;
               ev = f_eom && (i == f_n - 1);
               pl = (i == arb_byte) && (arb_bit == 8);
               if (pl) begin
                  base = m_exp.size();
                  done_n = base * f_div + 10 * f_div + f_div / 2 + 1;
                  arb = 1; fin = 1;
               end
               push_sym(ev ? 6 : 15, pl);
            end
            if (!fin) begin
               push_sym(6, f_ack[i]);
               if (!f_ack[i]) begin
                  nack = 1;
                  if (f_stop) fin = 1;
               end
            end
         end
         if (!arb) done_n = m_exp.size() * f_div;
      end
      e_res = txe ? 3 : arb ? 2 : nack ? 1 : 0;

      @(negedge clk);
      div_value = 16'(f_div);
      for (int i = 0; i < f_n && i < 16; i++) begin
         wr_en = 1'b1; wr_addr = 4'(i); wr_data = f_bytes[i];
         @(negedge clk);
      end
      wr_en = 1'b0;
      byte_count = 5'(f_n); sft_sel = 2'(f_sft);
      auto_som = f_som; auto_eom = f_eom; stop_on_nack = f_stop;
      start = 1'b1;
      @(posedge clk);
      for (int n = 0; n <= done_n + 3 * f_div; n++) begin
         int  j;
         bit  eo;
         @(negedge clk);
         j = n / f_div;
         peer_low = (j < m_peer.size()) ? m_peer[j] : 1'b0;
         start = (n == inject_n);
         eo = (j < m_exp.size()) ? m_exp[j] : 1'b0;
         if (cec_oe !== eo) bad_oe++;
         if (done !== (n == done_n)) bad_done++;
         if (busy !== (n < done_n)) bad_busy++;
         if (n == done_n) begin
            got_res = int'(result); got_ack = int'(ack_ok);
            got_arb = int'(arb_err); got_txe = int'(tx_err);
         end
      end
      peer_low = 1'b0;
      start = 1'b0;
      chk(bad_oe == 0, req, "line drive mismatching cycles", bad_oe, 0);
      chk(bad_done == 0, req, "done pulse mismatching cycles", bad_done, 0);
      chk(bad_busy == 0, req, "busy mismatching cycles", bad_busy, 0);
      chk(got_res == e_res, req, "R10 result code", got_res, e_res);
      chk(got_ack == int'(!txe && !arb && !nack), req, "ack_ok", got_ack, int'(!txe && !arb && !nack));
      chk(got_arb == int'(arb), req, "arb_err", got_arb, int'(arb));
      chk(got_txe == int'(txe), req, "tx_err", got_txe, int'(txe));
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 R10: quiet state after reset
      chk(cec_oe == 1'b0, "R12", "reset cec_oe", int'(cec_oe), 0);
      chk(busy == 1'b0 && done == 1'b0, "R10", "reset busy/done", int'({busy, done}), 0);
      chk({ack_ok, arb_err, tx_err, result} == 5'b0, "R10", "reset flags",
          int'({ack_ok, arb_err, tx_err, result}), 0);

      // R1 R2 R5 R6 R11: two acknowledged bytes, extra start mid-frame
      set_defaults();
      f_n = 2; f_bytes[0] = 8'h35; f_bytes[1] = 8'hC2; f_sft = 1; inject_n = 2000;
      run_frame("R1 R2 R5 R6 R11");

      // R1 R3 R6: other divisor, shortest wait, no acknowledge
      set_defaults();
      f_div = 6; f_bytes[0] = 8'hFF; f_ack[0] = 0;
      run_frame("R1 R3 R6");

      // R7: abort on the first missing acknowledge
      set_defaults();
      f_n = 3; f_bytes[0] = 8'hA5; f_bytes[1] = 8'h0F; f_bytes[2] = 8'h81;
      f_ack[1] = 0; f_sft = 2;
      run_frame("R7 stop");

      // R7: missing acknowledge without abort
      f_stop = 0;
      run_frame("R7 continue");

      // R8: arbitration lost on the second data bit
      set_defaults();
      f_n = 2; f_bytes[0] = 8'h55; f_bytes[1] = 8'h33; arb_byte = 0; arb_bit = 1;
      run_frame("R8 data");

      // R8: arbitration lost on the end-of-message bit
      set_defaults();
      f_bytes[0] = 8'h40; arb_byte = 0; arb_bit = 8;
      run_frame("R8 eom");

      // R4 R5: no start symbol, no end-of-message, longest wait
      set_defaults();
      f_n = 2; f_bytes[0] = 8'h12; f_bytes[1] = 8'h34; f_som = 0; f_eom = 0; f_sft = 3;
      run_frame("R4 R5");

      // R9 R12: refused byte counts
      set_defaults();
      f_n = 0;
      run_frame("R9 R12 zero");
      set_defaults();
      f_n = 17;
      run_frame("R9 R12 over");

      // R3: line busy before the wait restarts the count
      set_defaults();
      f_hold = 30; f_bytes[0] = 8'h80;
      run_frame("R3 restart");

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule